// File: doc/BRIEF.md
# Two-Source Output Buffer Interrupt Arbiter

This block sits between two byte sources of a legacy input controller, a keyboard channel and an auxiliary pointing-device channel, and the host side of that controller. Each source signals with a level that it has a byte waiting. The block keeps a two-bit record of which sources are waiting. From that record and the controller's mode byte it drives the buffer-full status flags, their copies in the output port and the two interrupt request levels.

The keyboard channel has priority. The auxiliary channel is shown to the host only when it is the single waiting source. Only then are its buffer-full flag and its interrupt raised, and only then does a host data read pop it. In every other case a host read pops the keyboard source. The interrupt levels and flags are registered, so they change only on a clock edge and cannot glitch when both sources change in the same cycle.

Top module: `obuf_irq_arbiter`

## Requirements
- R1: The pending record has one bit per source, bit 0 for keyboard and bit 1 for auxiliary. Each bit takes the value of its source's level input at every clock edge, and the outputs show the new record one cycle after the level changes.
- R2: `stat_obf_o` (status bit 0) is 1 exactly when at least one pending bit is set.
- R3: `stat_aux_obf_o` (status bit 5) is 1 only when the pending record is auxiliary-only, that is value 2'b10.
- R4: `aux_irq_o` is 1 exactly when the record is auxiliary-only and mode bit 1 (auxiliary interrupt enable) is set.
- R5: `kbd_irq_o` is 1 exactly when the keyboard pending bit is set, mode bit 0 (keyboard interrupt enable) is set and mode bit 4 (keyboard disable) is clear. The auxiliary bit has no effect on this output.
- R6: While `host_rd_i` is high, `pop_aux_o` is 1 if the registered record is auxiliary-only; otherwise `pop_kbd_o` is 1. Both pop outputs are 0 while `host_rd_i` is low. The pop outputs follow `host_rd_i` in the same cycle.
- R7: `port_obf_o` (output port bit 4) equals `stat_obf_o`, and `port_aux_obf_o` (output port bit 5) equals `stat_aux_obf_o`, in every cycle.
- R8: A change of `mode_i` alone, with the source levels held, updates both interrupt levels one clock edge later.
- R9: While reset is high, and whenever no source is pending, both interrupt levels and all four flag outputs are 0.
- R10: The two interrupt levels are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| kbd_avail_i | input | 1 | Keyboard source has a byte waiting (level) |
| aux_avail_i | input | 1 | Auxiliary source has a byte waiting (level) |
| mode_i | input | 8 | Controller mode byte: bit 0 keyboard irq enable, bit 1 aux irq enable, bit 4 keyboard disable |
| host_rd_i | input | 1 | Host data-read strobe |
| stat_obf_o | output | 1 | Status: output buffer full |
| stat_aux_obf_o | output | 1 | Status: auxiliary buffer full |
| port_obf_o | output | 1 | Output-port copy of the buffer-full flag |
| port_aux_obf_o | output | 1 | Output-port copy of the auxiliary buffer-full flag |
| kbd_irq_o | output | 1 | Keyboard interrupt request level |
| aux_irq_o | output | 1 | Auxiliary interrupt request level |
| pop_kbd_o | output | 1 | Host read pops the keyboard source |
| pop_aux_o | output | 1 | Host read pops the auxiliary source |

## Verification
Flags and interrupt levels are due one rising edge after a change of source levels or mode byte. The bench drives its inputs on the falling edge, waits for the next rising edge and samples one time unit later. The pop outputs have no register between `host_rd_i` and the port, but they depend on the record captured at the previous edge. The bench therefore raises the strobe on a falling edge after the record has settled and samples within the same half cycle. The checker compares each registered output with the inputs of the cycle before, after any cycle in reset.

// File: rtl/obi_pkg.sv
package obi_pkg;

    localparam int NUM_SRC  = 2;
    localparam int MODE_W   = 8;

    localparam int SRC_KBD  = 0;
    localparam int SRC_AUX  = 1;

    localparam int MODE_KBD_IRQ_EN = 0;
    localparam int MODE_AUX_IRQ_EN = 1;
    localparam int MODE_KBD_OFF    = 4;

    localparam logic [NUM_SRC-1:0] AUX_ONLY = NUM_SRC'(1 << SRC_AUX);

    typedef logic [NUM_SRC-1:0] pend_t;

    typedef struct packed {
        logic kbd_irq_en;
        logic aux_irq_en;
        logic kbd_off;
    } mode_ctl_t;

    typedef struct packed {
        logic obf;
        logic aux_obf;
        logic kbd_irq;
        logic aux_irq;
    } flags_t;

    localparam flags_t FLAGS_IDLE = '{obf: 1'b0, aux_obf: 1'b0, kbd_irq: 1'b0, aux_irq: 1'b0};

    function automatic mode_ctl_t mode_extract(input logic [MODE_W-1:0] m);
        mode_ctl_t c;
        c.kbd_irq_en = m[MODE_KBD_IRQ_EN];
        c.aux_irq_en = m[MODE_AUX_IRQ_EN];
        c.kbd_off    = m[MODE_KBD_OFF];
        return c;
    endfunction

    function automatic logic aux_alone(input pend_t p);
        return p == AUX_ONLY;
    endfunction

    function automatic logic any_pend(input pend_t p);
        return |p;
    endfunction

endpackage

// File: rtl/obi_pending_track.sv
module obi_pending_track
    import obi_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] avail_i,
    output logic [N-1:0] mask_d_o,
    output logic [N-1:0] mask_q_o
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= avail_i[g];
        end
        assign mask_d_o[g] = avail_i[g];
        assign mask_q_o[g] = bit_q;
    end
endmodule

// File: rtl/obi_flag_decode.sv
module obi_flag_decode
    import obi_pkg::*;
(
    input  pend_t     mask_i,
    input  mode_ctl_t ctl_i,
    output flags_t    flags_o
);
    always_comb begin
        flags_o = FLAGS_IDLE;
        if (any_pend(mask_i)) begin
            flags_o.obf = 1'b1;
            if (aux_alone(mask_i)) begin
                flags_o.aux_obf = 1'b1;
                flags_o.aux_irq = ctl_i.aux_irq_en;
            end else begin
                flags_o.kbd_irq = ctl_i.kbd_irq_en & ~ctl_i.kbd_off;
            end
        end
    end
endmodule

// File: rtl/obi_flag_reg.sv
module obi_flag_reg
    import obi_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t flags_d_i,
    output flags_t flags_q_o
);
    always_ff @(posedge clk) begin
        if (rst) flags_q_o <= FLAGS_IDLE;
        else     flags_q_o <= flags_d_i;
    end
endmodule

// File: rtl/obi_read_steer.sv
module obi_read_steer
    import obi_pkg::*;
(
    input  pend_t mask_q_i,
    input  logic  rd_i,
    output logic  pop_kbd_o,
    output logic  pop_aux_o
);
    logic sel_aux;
    always_comb begin
        sel_aux   = aux_alone(mask_q_i);
        pop_aux_o = rd_i & sel_aux;
        pop_kbd_o = rd_i & ~sel_aux;
    end
endmodule

// File: rtl/obuf_irq_arbiter.sv
module obuf_irq_arbiter
    import obi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              kbd_avail_i,
    input  logic              aux_avail_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              host_rd_i,
    output logic              stat_obf_o,
    output logic              stat_aux_obf_o,
    output logic              port_obf_o,
    output logic              port_aux_obf_o,
    output logic              kbd_irq_o,
    output logic              aux_irq_o,
    output logic              pop_kbd_o,
    output logic              pop_aux_o
);
    pend_t     avail;
    pend_t     mask_d;
    pend_t     mask_q;
    mode_ctl_t ctl;
    flags_t    flags_d;
    flags_t    flags_q;
    logic      unused_mode;

    always_comb begin
        avail          = '0;
        avail[SRC_KBD] = kbd_avail_i;
        avail[SRC_AUX] = aux_avail_i;
        ctl            = mode_extract(mode_i);
    end
    assign unused_mode = ^mode_i;

    obi_pending_track #(.N(NUM_SRC)) i_track (
        .clk      (clk),
        .rst      (rst),
        .avail_i  (avail),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q)
    );

    obi_flag_decode i_decode (
        .mask_i  (mask_d),
        .ctl_i   (ctl),
        .flags_o (flags_d)
    );

    obi_flag_reg i_freg (
        .clk       (clk),
        .rst       (rst),
        .flags_d_i (flags_d),
        .flags_q_o (flags_q)
    );

    obi_read_steer i_steer (
        .mask_q_i  (mask_q),
        .rd_i      (host_rd_i),
        .pop_kbd_o (pop_kbd_o),
        .pop_aux_o (pop_aux_o)
    );

    assign stat_obf_o     = flags_q.obf;
    assign stat_aux_obf_o = flags_q.aux_obf;
    assign port_obf_o     = flags_q.obf;
    assign port_aux_obf_o = flags_q.aux_obf;
    assign kbd_irq_o      = flags_q.kbd_irq;
    assign aux_irq_o      = flags_q.aux_irq;
endmodule

// File: rtl/obuf_irq_arbiter_chk.sv
module obuf_irq_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       kbd_avail_i,
    input logic       aux_avail_i,
    input logic [7:0] mode_i,
    input logic       host_rd_i,
    input logic       stat_obf_o,
    input logic       stat_aux_obf_o,
    input logic       port_obf_o,
    input logic       port_aux_obf_o,
    input logic       kbd_irq_o,
    input logic       aux_irq_o,
    input logic       pop_kbd_o,
    input logic       pop_aux_o
);
    assert_obf_any_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stat_obf_o == $past(kbd_avail_i | aux_avail_i)));

    assert_aux_obf_alone_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stat_aux_obf_o == $past(aux_avail_i & ~kbd_avail_i)));

    assert_aux_irq_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (aux_irq_o == $past(aux_avail_i & ~kbd_avail_i & mode_i[1])));

    assert_kbd_irq_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (kbd_irq_o == $past(kbd_avail_i & mode_i[0] & ~mode_i[4])));

    assert_pop_steer_R6: assert property (@(posedge clk) disable iff (rst)
        (host_rd_i && !$past(rst)) |-> (pop_aux_o == $past(aux_avail_i & ~kbd_avail_i)));

    assert_pop_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pop_kbd_o, pop_aux_o}) && (host_rd_i == (pop_kbd_o | pop_aux_o)));

    assert_port_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        (port_obf_o == stat_obf_o) && (port_aux_obf_o == stat_aux_obf_o));

    assert_irq_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({kbd_irq_o, aux_irq_o}));

    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(stat_obf_o | stat_aux_obf_o | kbd_irq_o | aux_irq_o));
endmodule

bind obuf_irq_arbiter obuf_irq_arbiter_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .kbd_avail_i    (kbd_avail_i),
    .aux_avail_i    (aux_avail_i),
    .mode_i         (mode_i),
    .host_rd_i      (host_rd_i),
    .stat_obf_o     (stat_obf_o),
    .stat_aux_obf_o (stat_aux_obf_o),
    .port_obf_o     (port_obf_o),
    .port_aux_obf_o (port_aux_obf_o),
    .kbd_irq_o      (kbd_irq_o),
    .aux_irq_o      (aux_irq_o),
    .pop_kbd_o      (pop_kbd_o),
    .pop_aux_o      (pop_aux_o)
);

// File: tb/test_obuf_irq_arbiter.sv
module test_obuf_irq_arbiter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kbd_avail_i = 1'b0;
    logic       aux_avail_i = 1'b0;
    logic [7:0] mode_i = 8'h00;
    logic       host_rd_i = 1'b0;
    logic       stat_obf_o, stat_aux_obf_o, port_obf_o, port_aux_obf_o;
    logic       kbd_irq_o, aux_irq_o, pop_kbd_o, pop_aux_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    obuf_irq_arbiter i_obuf_irq_arbiter (
        .clk(clk), .rst(rst),
        .kbd_avail_i(kbd_avail_i), .aux_avail_i(aux_avail_i),
        .mode_i(mode_i), .host_rd_i(host_rd_i),
        .stat_obf_o(stat_obf_o), .stat_aux_obf_o(stat_aux_obf_o),
        .port_obf_o(port_obf_o), .port_aux_obf_o(port_aux_obf_o),
        .kbd_irq_o(kbd_irq_o), .aux_irq_o(aux_irq_o),
        .pop_kbd_o(pop_kbd_o), .pop_aux_o(pop_aux_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // {stat_obf, stat_aux, port_obf, port_aux, kbd_irq, aux_irq}
    function automatic logic [7:0] outs();
        return {2'b00, stat_obf_o, stat_aux_obf_o, port_obf_o, port_aux_obf_o, kbd_irq_o, aux_irq_o};
    endfunction

    // Expected outputs derived from the requirement text
    function automatic logic [7:0] expect_outs(input logic k, input logic a, input logic [7:0] m);
        logic obf, aobf, kirq, airq;
        obf  = k | a;
        aobf = a & ~k;
        airq = aobf & m[1];
        kirq = k & m[0] & ~m[4];
        return {2'b00, obf, aobf, obf, aobf, kirq, airq};
    endfunction

    task automatic apply(input logic k, input logic a, input logic [7:0] m);
        @(negedge clk);
        kbd_avail_i = k;
        aux_avail_i = a;
        mode_i      = m;
        @(posedge clk);
        #1;
    endtask

    task automatic apply_check(input string tag, input logic k, input logic a, input logic [7:0] m);
        apply(k, a, m);
        check(tag, outs(), expect_outs(k, a, m));
    endtask

    task automatic read_check(input string tag, input logic exp_kbd, input logic exp_aux);
        @(negedge clk);
        host_rd_i = 1'b1;
        #1;
        check(tag, {6'd0, pop_kbd_o, pop_aux_o}, {6'd0, exp_kbd, exp_aux});
        @(negedge clk);
        host_rd_i = 1'b0;
        #1;
        check({tag, " idle"}, {6'd0, pop_kbd_o, pop_aux_o}, 8'd0);
    endtask

    task automatic t_reset();
        kbd_avail_i = 1'b1;
        aux_avail_i = 1'b1;
        mode_i      = 8'h03;
        repeat (3) @(posedge clk);
        #1;
        check("R9 outputs in reset", outs(), 8'd0);
        @(negedge clk);
        kbd_avail_i = 1'b0;
        aux_avail_i = 1'b0;
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R9 idle after reset", outs(), 8'd0);
    endtask

    task automatic t_kbd_only();
        apply_check("R1 R2 R5 kbd pending irq on", 1'b1, 1'b0, 8'h03);
        apply_check("R5 kbd disabled by mode bit 4", 1'b1, 1'b0, 8'h13);
        apply_check("R5 kbd irq enable clear", 1'b1, 1'b0, 8'h02);
        read_check("R6 pop keyboard when kbd only", 1'b1, 1'b0);
    endtask

    task automatic t_aux_only();
        apply_check("R3 R4 R7 aux only irq on", 1'b0, 1'b1, 8'h03);
        apply_check("R4 aux irq enable clear", 1'b0, 1'b1, 8'h01);
        read_check("R6 pop aux when aux only", 1'b0, 1'b1);
    endtask

    task automatic t_both();
        apply_check("R3 R5 R10 both pending kbd wins", 1'b1, 1'b1, 8'h03);
        read_check("R6 pop keyboard when both", 1'b1, 1'b0);
        apply_check("R5 both pending kbd disabled, aux stays silent", 1'b1, 1'b1, 8'h12);
        apply_check("R10 swap both to aux only in one cycle", 1'b0, 1'b1, 8'h03);
        apply_check("R10 swap aux to kbd only in one cycle", 1'b1, 1'b0, 8'h03);
    endtask

    task automatic t_mode_change();
        apply_check("R8 setup kbd pending irq off", 1'b1, 1'b0, 8'h00);
        apply_check("R8 mode alone raises kbd irq", 1'b1, 1'b0, 8'h01);
        apply_check("R8 mode alone drops kbd irq", 1'b1, 1'b0, 8'h11);
        apply_check("R8 setup aux pending", 1'b0, 1'b1, 8'h00);
        apply_check("R8 mode alone raises aux irq", 1'b0, 1'b1, 8'h02);
    endtask

    task automatic t_idle();
        apply_check("R9 nothing pending all clear", 1'b0, 1'b0, 8'hFF);
        read_check("R6 pop keyboard when empty", 1'b1, 1'b0);
        // R1: one cycle latency, output still old before the edge
        @(negedge clk);
        aux_avail_i = 1'b1;
        mode_i      = 8'h02;
        #1;
        check("R1 no change before edge", outs(), 8'd0);
        @(posedge clk);
        #1;
        check("R1 change after one edge", outs(), expect_outs(1'b0, 1'b1, 8'h02));
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_kbd_only();
                t_aux_only();
                t_both();
                t_mode_change();
                t_idle();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule